// File: doc/BRIEF.md
# Timestamped Cluster Capture Writer

This block is the write side of a logic-analyser sample store. It watches a 16-bit input bus on a strobe divided down from the core clock and keeps a timestamp that advances once per strobe. Whenever the bus changes it opens a cluster: the timestamp of that strobe, then the sample of that strobe and of the six strobes after it. Full clusters go out on a wide synchronous write port, 64 to a memory line of 1024 bytes. Strobes on which the bus holds still produce no cluster. The reader fills those gaps from the timestamp difference between clusters.

Software arms the block and programs the divider and the post-trigger length. The block keeps a write position, latches that position when the trigger arrives, and stops when the post-trigger interval has been sampled or when memory is full. On a stop it writes out any partly filled cluster and reports where the valid data ends.

Top module: `ctw_capture_writer`

## Requirements
- R1: A strobe occurs once every `frac`+1 clocks while capturing. The first strobe falls on the `frac`+1-th clock after the arm cycle. The timestamp starts at 0 on arm and advances by one per strobe, modulo 2^TS_W.
- R2: A cluster write carries the opening timestamp in `wr_data[127:112]`, high byte in [127:120]. Sample k (k = 0..6) sits in `wr_data[111-16k -: 16]` and is the sample of strobe timestamp+k.
- R3: A cluster opens only on a strobe whose sample differs from the last stored sample, which is 0 after arm. Unchanged strobes outside a cluster cause no write.
- R4: `wr_addr` is {line, cluster}, with the cluster index in the low 6 bits. The position is {line, event}, with event = cluster*7 + filled slots in bits [8:0]. The line advances after 64 clusters (448 events).
- R5: When 2^TS_W-1 strobes have passed since the last cluster opened (or since arm) with no change, a cluster is opened anyway.
- R6: The first `trig_in` high while capturing sets `triggered` and latches `trig_pos` as the position of the next event to be written. Later pulses are ignored until the next arm.
- R7: After the trigger cycle exactly `post_len` further strobes are sampled. The next strobe stops capture. A partly filled cluster is written out with its empty slots padded with the last stored sample.
- R8: On stop, `busy` falls and `done` rises. `stop_pos` holds the position of the first unwritten event. No write follows until the next arm.
- R9: When a completed cluster brings the line index to 2^LINE_W-1, capture stops at once with `stop_pos` = {2^LINE_W-1, 0}.
- R10: `arm` in any state restarts capture. It clears `triggered`, `trig_pos`, `stop_pos`, the timestamp and the position.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start or restart a capture |
| frac | input | FRAC_W | Strobe divider: one strobe per frac+1 clocks |
| post_len | input | POST_W | Strobes sampled after the trigger |
| smp_in | input | SMP_W | Sampled input bus |
| trig_in | input | 1 | Trigger pulse |
| wr_en | output | 1 | Cluster write strobe |
| wr_addr | output | LINE_W+6 | {line, cluster} |
| wr_data | output | 128 | Timestamp word then seven sample words |
| busy | output | 1 | Capture running |
| done | output | 1 | Capture stopped |
| triggered | output | 1 | Trigger latched |
| trig_pos | output | LINE_W+9 | {line, event} at trigger |
| stop_pos | output | LINE_W+9 | {line, event} of first unwritten event |

## Verification
Every output is registered, so a stimulus applied before an edge shows its result on that edge: the trigger latch, the stop flags and the cluster write all land one clock after the deciding cycle. That cycle is the strobe for writes and stops, and the trigger cycle for the latch. The bench model takes the same inputs at the same edge and updates its expected values there, then compares every output at the following falling edge. The directed checks count edges from the arm pulse: the trigger and the first strobe both fall on the first edge after the arm edge, so the padded cluster of the short capture is due on the fourth edge after arm.

// File: rtl/ctw_pkg.sv
package ctw_pkg;
   localparam int EPC       = 7;
   localparam int CPL       = 64;
   localparam int EPL       = EPC * CPL;
   localparam int EVT_W     = 9;
   localparam int CLU_W     = 6;
   localparam int SLOT_W    = 3;
   localparam int WORD_W    = 16;
   localparam int CLU_BITS  = WORD_W * (EPC + 1);

   typedef enum logic [1:0] {
      CAP_IDLE = 2'd0,
      CAP_RUN  = 2'd1,
      CAP_DONE = 2'd2
   } cap_state_e;
endpackage

// File: rtl/ctw_strobe_div.sv
module ctw_strobe_div #(
   parameter int FRAC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [FRAC_W-1:0] frac,
   output logic              stb
);
   logic [FRAC_W-1:0] cnt;
   logic              hit;

   assign hit = (cnt >= frac);
   assign stb = en && !clr && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clr || !en)   cnt <= '0;
      else if (hit)          cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

   // R1: with a fixed nonzero divider two strobes are never adjacent
   a_r1_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && frac != '0 && $stable(frac)) |=> !stb);
endmodule

// File: rtl/ctw_trig_ctl.sv
module ctw_trig_ctl #(
   parameter int POS_W  = 24,
   parameter int POST_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic              trig_in,
   input  logic              stb,
   input  logic [POST_W-1:0] post_len,
   input  logic [POS_W-1:0]  cur_pos,
   output logic              triggered,
   output logic [POS_W-1:0]  trig_pos,
   output logic              post_done
);
   logic [POST_W-1:0] post_cnt;

   assign post_done = triggered && (post_cnt == post_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         triggered <= 1'b0;
         trig_pos  <= '0;
         post_cnt  <= '0;
      end else if (clr) begin
         triggered <= 1'b0;
         trig_pos  <= '0;
         post_cnt  <= '0;
      end else begin
         if (en && trig_in && !triggered) begin
            triggered <= 1'b1;
            trig_pos  <= cur_pos;
         end
         if (en && stb && triggered && !post_done)
            post_cnt <= post_cnt + 1'b1;
      end
   end

   // R6: once latched, the trigger position holds until the next arm
   a_r6_pos_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (triggered && !clr) |=> (triggered && $stable(trig_pos)));
endmodule

// File: rtl/ctw_cluster_pack.sv
module ctw_cluster_pack import ctw_pkg::*; #(
   parameter int LINE_W = 15,
   parameter int TS_W   = 16,
   parameter int SMP_W  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      take,
   input  logic                      flush,
   input  logic [SMP_W-1:0]          smp,
   output logic                      wr_en,
   output logic [LINE_W+CLU_W-1:0]   wr_addr,
   output logic [CLU_BITS-1:0]       wr_data,
   output logic [LINE_W+EVT_W-1:0]   cur_pos,
   output logic                      full_hit
);
   localparam logic [TS_W-1:0]   GAP_LIM   = {{(TS_W-1){1'b1}}, 1'b0};
   localparam logic [LINE_W-1:0] LINE_LAST = {LINE_W{1'b1}} - 1'b1;
   localparam logic [SLOT_W-1:0] SLOT_END  = SLOT_W'(EPC - 1);
   localparam logic [CLU_W-1:0]  CLU_END   = CLU_W'(CPL - 1);

   logic [TS_W-1:0]   ts, gap, open_ts;
   logic [SMP_W-1:0]  last;
   logic [SLOT_W-1:0] slot;
   logic [CLU_W-1:0]  clu;
   logic [LINE_W-1:0] line;
   logic [EVT_W-1:0]  evt;

   logic opening, storing, closing, pad_flush, emit, line_wrap;
   logic [CLU_BITS-1:0] data_nx;

   assign opening   = take && (slot == '0) && ((smp != last) || (gap == GAP_LIM));
   assign storing   = take && ((slot != '0) || opening);
   assign closing   = storing && (slot == SLOT_END);
   assign pad_flush = flush && (slot != '0);
   assign emit      = closing || pad_flush;
   assign line_wrap = closing && (clu == CLU_END);
   assign full_hit  = line_wrap && (line == LINE_LAST);
   assign cur_pos   = {line, evt};

   assign data_nx[CLU_BITS-1 -: WORD_W] = WORD_W'(open_ts);

   for (genvar k = 0; k < EPC; k++) begin : g_slot
      logic [SMP_W-1:0] held;
      logic [SMP_W-1:0] word_nx;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  held <= '0;
         else if (storing && slot == SLOT_W'(k))      held <= smp;
      end

      always_comb begin
         if (storing && slot == SLOT_W'(k))           word_nx = smp;
         else if (pad_flush && slot <= SLOT_W'(k))    word_nx = last;
         else                                         word_nx = held;
      end

      assign data_nx[CLU_BITS-WORD_W*(k+2) +: WORD_W] = WORD_W'(word_nx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ts <= '0; gap <= '0; open_ts <= '0; last <= '0;
         slot <= '0; clu <= '0; line <= '0; evt <= '0;
         wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      end else if (clr) begin
         ts <= '0; gap <= '0; open_ts <= '0; last <= '0;
         slot <= '0; clu <= '0; line <= '0; evt <= '0;
         wr_en <= 1'b0;
      end else begin
         wr_en <= emit;
         if (emit) begin
            wr_addr <= {line, clu};
            wr_data <= data_nx;
         end
         if (take) begin
            ts  <= ts + 1'b1;
            gap <= opening ? '0 : gap + 1'b1;
         end
         if (storing) begin
            last <= smp;
            evt  <= line_wrap ? '0 : evt + 1'b1;
            slot <= closing ? '0 : slot + 1'b1;
            if (opening) open_ts <= ts;
         end
         if (closing) begin
            clu <= clu + 1'b1;
            if (line_wrap) line <= line + 1'b1;
         end
      end
   end

   // R4: event index always agrees with cluster index and filled slots
   a_r4_evt_consistent: assert property (@(posedge clk) disable iff (!rst_n)
      evt == (EVT_W'(clu) * EVT_W'(EPC) + EVT_W'(slot)));

   // R2: a cluster never holds more than seven samples
   a_r2_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
      slot <= SLOT_END);

   // R9: the last line index is never written
   a_r9_no_full_line_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr[LINE_W+CLU_W-1:CLU_W] != {LINE_W{1'b1}}));

   // R3: an unchanged strobe outside a cluster leaves the cluster closed
   a_r3_quiet_stays_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !clr && slot == '0 && smp == last && gap != GAP_LIM) |=> (slot == '0));
endmodule

// File: rtl/ctw_capture_writer.sv
module ctw_capture_writer import ctw_pkg::*; #(
   parameter int LINE_W = 15,
   parameter int TS_W   = 16,
   parameter int FRAC_W = 8,
   parameter int POST_W = 16,
   parameter int SMP_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     arm,
   input  logic [FRAC_W-1:0]        frac,
   input  logic [POST_W-1:0]        post_len,
   input  logic [SMP_W-1:0]         smp_in,
   input  logic                     trig_in,
   output logic                     wr_en,
   output logic [LINE_W+CLU_W-1:0]  wr_addr,
   output logic [CLU_BITS-1:0]      wr_data,
   output logic                     busy,
   output logic                     done,
   output logic                     triggered,
   output logic [LINE_W+EVT_W-1:0]  trig_pos,
   output logic [LINE_W+EVT_W-1:0]  stop_pos
);
   localparam int POS_W = LINE_W + EVT_W;
   localparam logic [POS_W-1:0] FULL_POS = {{LINE_W{1'b1}}, {EVT_W{1'b0}}};

   if (LINE_W < 1 || LINE_W > 15) begin : g_bad_line
      $error("LINE_W must lie in 1..15");
   end
   if (TS_W < 4 || TS_W > WORD_W) begin : g_bad_ts
      $error("TS_W must lie in 4..16");
   end
   if (SMP_W < 1 || SMP_W > WORD_W) begin : g_bad_smp
      $error("SMP_W must lie in 1..16");
   end
   if (FRAC_W < 1 || POST_W < 1) begin : g_bad_cnt
      $error("FRAC_W and POST_W must be at least 1");
   end

   cap_state_e       st;
   logic             run, stb, post_done, take, flush, full_hit;
   logic [POS_W-1:0] cur_pos;

   assign run   = (st == CAP_RUN);
   assign take  = run && stb && !post_done;
   assign flush = run && stb && post_done;
   assign busy  = run;
   assign done  = (st == CAP_DONE);

   ctw_strobe_div #(.FRAC_W(FRAC_W)) u_div (
      .clk(clk), .rst_n(rst_n), .clr(arm), .en(run), .frac(frac), .stb(stb));

   ctw_trig_ctl #(.POS_W(POS_W), .POST_W(POST_W)) u_trig (
      .clk(clk), .rst_n(rst_n), .clr(arm), .en(run), .trig_in(trig_in),
      .stb(stb), .post_len(post_len), .cur_pos(cur_pos),
      .triggered(triggered), .trig_pos(trig_pos), .post_done(post_done));

   ctw_cluster_pack #(.LINE_W(LINE_W), .TS_W(TS_W), .SMP_W(SMP_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr(arm), .take(take), .flush(flush),
      .smp(smp_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cur_pos(cur_pos), .full_hit(full_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= CAP_IDLE;
         stop_pos <= '0;
      end else if (arm) begin
         st       <= CAP_RUN;
         stop_pos <= '0;
      end else if (run && (flush || full_hit)) begin
         st       <= CAP_DONE;
         stop_pos <= flush ? cur_pos : FULL_POS;
      end
   end

   // R8: nothing is written once the capture has stopped
   a_r8_quiet_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !wr_en);

   // R9: writing the last cluster below the full line ends the capture
   a_r9_full_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == {FULL_POS[POS_W-1:EVT_W] - 1'b1, {CLU_W{1'b1}}}) |-> done);

   // R8: busy and done are never both set
   a_r8_exclusive_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
endmodule

// File: tb/ctw_capture_writer_test.sv
`timescale 1ns/1ps
module ctw_capture_writer_test;
   localparam int LW = 2;
   localparam int TW = 6;
   localparam int LMAX = (1 << LW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0, trig_in = 1'b0;
   logic [7:0] frac = '0, post_len = '0;
   logic [15:0] smp_in = '0;
   logic wr_en, busy, done, triggered;
   logic [LW+5:0] wr_addr;
   logic [127:0] wr_data;
   logic [LW+8:0] trig_pos, stop_pos;

   always #2.5 clk = ~clk;

   ctw_capture_writer #(.LINE_W(LW), .TS_W(TW), .FRAC_W(8), .POST_W(8), .SMP_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .frac(frac), .post_len(post_len),
      .smp_in(smp_in), .trig_in(trig_in), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .done(done), .triggered(triggered),
      .trig_pos(trig_pos), .stop_pos(stop_pos));

   int n_chk = 0, n_fail = 0, tick = 0;
   string scn = "R11";

   task automatic chk(input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s (%s) %s actual=%0h expected=%0h", tag, scn, what, act, exp);
      end
   endtask

   // reference model
   int m_div, m_ts, m_since, m_post, m_ncl, m_open_ts, m_last, m_trgpos, m_stoppos, m_addr;
   int q[$];
   bit m_run, m_done, m_trg, m_wr;
   logic [127:0] m_data;

   function automatic int m_pos();
      return (m_ncl / 64) * 512 + (m_ncl % 64) * 7 + q.size();
   endfunction

   task automatic m_emit();
      m_wr = 1;
      m_addr = (m_ncl / 64) * 64 + (m_ncl % 64);
      m_data = '0;
      m_data[127:112] = 16'(m_open_ts);
      for (int k = 0; k < 7; k++)
         m_data[111-16*k -: 16] = (k < q.size()) ? 16'(q[k]) : 16'(m_last);
   endtask

   always @(posedge clk) begin
      m_wr = 0;
      if (!rst_n) begin
         m_run = 0; m_done = 0; m_trg = 0; m_trgpos = 0; m_stoppos = 0;
         m_div = 0; m_ts = 0; m_since = 0; m_post = 0; m_ncl = 0; m_last = 0;
         q.delete();
      end else if (arm) begin
         m_run = 1; m_done = 0; m_trg = 0; m_trgpos = 0; m_stoppos = 0;
         m_div = 0; m_ts = 0; m_since = 0; m_post = 0; m_ncl = 0; m_last = 0;
         q.delete();
      end else if (m_run) begin
         automatic int  pos = m_pos();
         automatic bit  was_trg = m_trg;
         automatic bit  stb = (m_div >= int'(frac));
         m_div = stb ? 0 : m_div + 1;
         if (stb) begin
            if (was_trg && m_post == int'(post_len)) begin
               if (q.size() > 0) m_emit();
               m_stoppos = pos; m_run = 0; m_done = 1;
            end else begin
               if (was_trg) m_post++;
               if (q.size() > 0 || int'(smp_in) != m_last || m_since + 1 == (1 << TW) - 1) begin
                  if (q.size() == 0) begin m_open_ts = m_ts; m_since = 0; end
                  else m_since++;
                  q.push_back(int'(smp_in));
                  m_last = int'(smp_in);
                  if (q.size() == 7) begin
                     m_emit();
                     m_ncl++;
                     q.delete();
                     if (m_ncl / 64 == LMAX) begin
                        m_run = 0; m_done = 1; m_stoppos = LMAX * 512;
                     end
                  end
               end else m_since++;
               m_ts = (m_ts + 1) % (1 << TW);
            end
         end
         if (trig_in && !was_trg) begin m_trg = 1; m_trgpos = pos; end
      end
   end

   always @(negedge clk) begin
      chk("R3", "wr_en", wr_en, m_wr);
      if (m_wr) begin
         chk("R4", "wr_addr", wr_addr, m_addr);
         chk("R2", "wr_data", wr_data, m_data);
      end
      chk("R10", "busy", busy, m_run);
      chk("R8", "done", done, m_done);
      chk("R6", "triggered", triggered, m_trg);
      chk("R6", "trig_pos", trig_pos, m_trgpos);
      chk("R8", "stop_pos", stop_pos, m_stoppos);
   end

   task automatic drive(input int n, input int mode);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick++;
         case (mode)
            0: smp_in = 16'(tick);
            2: smp_in = ~smp_in;
            3: if (tick % 17 == 0) smp_in = smp_in + 16'h0101;
            default: ;
         endcase
      end
   endtask

   task automatic pulse_arm();
      arm = 1'b1; @(negedge clk); arm = 1'b0;
   endtask

   task automatic pulse_trig();
      trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
   endtask

   task automatic wait_done(input int mode, input int limit);
      for (int i = 0; i < limit && !done; i++) drive(1, mode);
      if (!done) begin
         n_fail++;
         $display("FAIL %s capture did not stop actual=0 expected=1", scn);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11", "reset wr_en", wr_en, 0);
      chk("R11", "reset busy", busy, 0);
      chk("R11", "reset done", done, 0);
      chk("R11", "reset triggered", triggered, 0);
      chk("R11", "reset trig_pos", trig_pos, 0);
      chk("R11", "reset stop_pos", stop_pos, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: short capture, trigger with the first strobe, two more strobes, pad
      scn = "R7"; frac = 0; post_len = 2; arm = 1'b1;
      @(negedge clk); arm = 1'b0; smp_in = 16'd1; trig_in = 1'b1;
      @(negedge clk); trig_in = 1'b0; smp_in = 16'd2;
      @(negedge clk); smp_in = 16'd3;
      @(negedge clk); smp_in = 16'd4;
      @(negedge clk);
      chk("R7", "padded write", wr_en, 1);
      chk("R7", "padded data", wr_data, 128'h0000_0001_0002_0003_0003_0003_0003_0003);
      chk("R8", "stop_pos", stop_pos, 3);
      chk("R6", "trig_pos", trig_pos, 0);
      chk("R8", "done", done, 1);
      @(negedge clk);
      chk("R8", "no write after stop", wr_en, 0);

      // R1: divided strobe with a changing bus
      scn = "R1"; frac = 3; post_len = 20;
      pulse_arm(); drive(300, 0); pulse_trig(); wait_done(0, 2000);

      // R5: constant bus forces clusters; R3: sparse changes
      scn = "R5"; frac = 0; post_len = 10; smp_in = '0;
      pulse_arm(); drive(200, 1);
      scn = "R3"; drive(300, 3); pulse_trig(); wait_done(3, 500);

      // R9: toggling bus fills memory
      scn = "R9"; frac = 0; post_len = 0;
      pulse_arm(); wait_done(2, 3000);
      chk("R9", "full stop_pos", stop_pos, LMAX * 512);
      chk("R9", "no trigger", triggered, 0);

      // R6: second trigger pulse ignored
      scn = "R6"; frac = 1; post_len = 5;
      pulse_arm(); drive(40, 0); pulse_trig(); drive(2, 0); pulse_trig();
      wait_done(0, 200);

      // R10: re-arm during a triggered capture
      scn = "R10";
      pulse_arm(); drive(30, 0); pulse_trig(); drive(3, 0); pulse_arm();
      chk("R10", "triggered cleared", triggered, 0);
      chk("R10", "busy after re-arm", busy, 1);
      chk("R10", "trig_pos cleared", trig_pos, 0);
      chk("R10", "stop_pos cleared", stop_pos, 0);
      drive(20, 0); pulse_trig(); wait_done(0, 200);

      drive(3, 1);
      finish_up();
   end
endmodule